// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo audio stream on a three-wire serial link and turns it into parallel left and right samples. The three wires are a bit clock, a left/right framing clock and a data line. The block oversamples all three in its own faster system clock. It understands four framing formats: right-justified, I2S, left-justified and a pulse-framed DSP format. It accepts word lengths of 16, 18, 20 and 24 bits. Samples are two's complement and sent MSB first, and the left field always comes before the right field of the same pair.

The format comes from a 2-bit code. That code is the bitwise OR of an external pin pair and a control register field, so either source can select a format while the other is held at zero. A separate 2-bit register input sets the word length used in right-justified mode. When a left word and then a right word have been captured, both are presented together with a one-cycle strobe. Each channel also has a flag that rises after a long run of all-zero samples on that channel.

Top module: `audio_serial_rx`

## Requirements
- R1: The effective format code is `mode_pin_i | mode_reg_i`, with the following codes: 2'b00 right-justified, 2'b01 I2S, 2'b10 left-justified, 2'b11 DSP.
- R2: In I2S format, a low framing clock marks the left field. Bits are taken on the rising bit-clock edge, and the MSB is taken on the second rising edge after a framing-clock transition.
- R3: In left-justified format, a high framing clock marks the left field. Bits are taken on the rising bit-clock edge, with the MSB on the first rising edge after the transition. Half-frames of any length up to 32 bit clocks are accepted.
- R4: In right-justified format, a high framing clock marks the left field. Counting the first rising edge after a transition as slot 0, the word starts at slot 8, 12 or 16 when `rj_len_i` is 2'b00 (24 bits), 2'b01 (20 bits) or 2'b10 (16 bits). Code 2'b11 acts as 24 bits. Bits in the earlier slots are ignored.
- R5: In DSP format, bits are taken on the falling bit-clock edge. A sampling edge that sees the framing clock newly high opens a field, and the MSB is taken on the next sampling edge. The first such pulse after reset opens a left field, and the fields alternate from then on.
- R6: Outside right-justified format, a word of N ≤ 24 bits is delivered MSB-aligned in the 24-bit output with zeros in the low 24−N bits. Bits beyond the 24th are discarded.
- R7: A captured field is complete when the next field boundary is seen. When a right field completes after a left field, `pair_valid_o` pulses high for one cycle, and `left_o` and `right_o` change together in that same cycle.
- R8: A channel's zero flag is high once more than ZERO_FRAMES consecutive delivered pairs have carried an all-zero word on that channel. It falls on the first pair with a nonzero word on that channel.
- R9: While `rst` is high, `left_o` and `right_o` are zero and `pair_valid_o`, `zero_left_o` and `zero_right_o` are low. Framing tracking starts over after reset.
- R10: `left_o` and `right_o` keep their values in every cycle in which `pair_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrclk_i | input | 1 | Left/right framing clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| mode_pin_i | input | 2 | Format code from external pins |
| mode_reg_i | input | 2 | Format code from control register |
| rj_len_i | input | 2 | Right-justified word length code |
| left_o | output | W | Left sample of the last delivered pair |
| right_o | output | W | Right sample of the last delivered pair |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| zero_left_o | output | 1 | Long-silence flag, left channel |
| zero_right_o | output | 1 | Long-silence flag, right channel |

## Verification
The bench aims at the edges of the capture window in each format.

- **I2S offset.** A design that misses the one-slot MSB delay in I2S would deliver every word shifted by one bit.
- **Right-justified start slot.** Garbage ones are placed in the slots before the right-justified start point. A wrong start slot would pull those ones into the high bits.
- **Word length.** Words shorter than 24 bits and words longer than 24 bits are both sent, to catch low bits that are not zeroed and overflow bits that leak in.
- **DSP mode.** It is reached only through the OR of pin and register codes, and it samples on the opposite edge. A design that swapped edges, or ignored either code source, would produce wrong or missing pairs.
- **Zero flag threshold.** The flag is probed just at its threshold, one pair past it, and when one channel resumes. This exposes off-by-one counting and flags that are shared between channels.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // Right-justified word length from its 2-bit code (R4).
  function automatic int rj_width(input logic [1:0] code, input int full_w);
    case (code)
      2'b01:   return full_w - 4;
      2'b10:   return full_w - 8;
      default: return full_w;
    endcase
  endfunction

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/asr_field_capture.sv
module asr_field_capture
  import asr_pkg::*;
#(
  parameter int W         = 24,
  parameter int MAX_SLOTS = 64,
  parameter int RJ_SLOTS  = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en_i,
  input  logic         lr_i,
  input  logic         sd_i,
  input  fmt_e         fmt_i,
  input  logic [1:0]   rj_len_i,
  output logic         commit_o,
  output logic         commit_left_o,
  output logic [W-1:0] word_o
);

  localparam int IDX_W = $clog2(MAX_SLOTS);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(MAX_SLOTS - 1);

  logic             prev_lr_q, seen_q, armed_q, cur_left_q, dsp_next_left_q;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [W-1:0]     acc_q, acc_n;
  logic             boundary, new_left;
  int               off_v, len_v, rel;

  // Field boundary and channel of the field that opens there (R2, R3, R5).
  always_comb begin
    if (fmt_i == FMT_DSP) boundary = seen_q && lr_i && !prev_lr_q;
    else                  boundary = seen_q && (lr_i != prev_lr_q);
    case (fmt_i)
      FMT_DSP: new_left = dsp_next_left_q;
      FMT_I2S: new_left = !lr_i;
      default: new_left = lr_i;
    endcase
  end

  // Capture window: first slot and length per format (R2..R6).
  always_comb begin
    case (fmt_i)
      FMT_LJ:  begin off_v = 0; len_v = W; end
      FMT_RJ:  begin len_v = rj_width(rj_len_i, W); off_v = RJ_SLOTS - len_v; end
      default: begin off_v = 1; len_v = W; end
    endcase
  end

  always_comb begin
    if (boundary)            idx_n = '0;
    else if (idx_q == IDX_MAX) idx_n = idx_q;
    else                     idx_n = idx_q + 1'b1;
    acc_n = boundary ? '0 : acc_q;
    rel   = int'(idx_n) - off_v;
    for (int b = 0; b < W; b++) begin
      if (rel >= 0 && rel < len_v && rel == W - 1 - b) acc_n[b] = sd_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lr_q       <= 1'b0;
      seen_q          <= 1'b0;
      armed_q         <= 1'b0;
      cur_left_q      <= 1'b0;
      dsp_next_left_q <= 1'b1;
      idx_q           <= '0;
      acc_q           <= '0;
      commit_o        <= 1'b0;
      commit_left_o   <= 1'b0;
      word_o          <= '0;
    end else begin
      commit_o <= 1'b0;
      if (smp_en_i) begin
        prev_lr_q <= lr_i;
        seen_q    <= 1'b1;
        idx_q     <= idx_n;
        acc_q     <= acc_n;
        if (boundary) begin
          commit_o      <= armed_q;
          commit_left_o <= cur_left_q;
          word_o        <= acc_q;
          cur_left_q    <= new_left;
          armed_q       <= 1'b1;
          if (fmt_i == FMT_DSP) dsp_next_left_q <= !dsp_next_left_q;
        end
      end
    end
  end

endmodule

// File: rtl/asr_zero_watch.sv
module asr_zero_watch #(
  parameter int W     = 24,
  parameter int LIMIT = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_i,
  input  logic [W-1:0] word_i,
  output logic         flag_o
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_P1 = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (word_i != '0)        cnt_n = '0;
    else if (cnt_q == LIM_P1) cnt_n = cnt_q;
    else                     cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (strobe_i) begin
      cnt_q  <= cnt_n;
      flag_o <= (cnt_n > LIM_C);  // R8
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int W           = 24,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_SLOTS   = 64,
  parameter int RJ_SLOTS    = 32,
  parameter int ZERO_FRAMES = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bclk_i,
  input  logic         lrclk_i,
  input  logic         sdata_i,
  input  logic [1:0]   mode_pin_i,
  input  logic [1:0]   mode_reg_i,
  input  logic [1:0]   rj_len_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         pair_valid_o,
  output logic         zero_left_o,
  output logic         zero_right_o
);

  localparam int NCH = 2;

  fmt_e         fmt;
  logic [2:0]   pins_s;
  logic         bclk_s, lr_s, sd_s, bclk_q, smp_en;
  logic         commit, commit_left;
  logic [W-1:0] word;
  logic [W-1:0] staged_q;
  logic         have_left_q, pair_fire;
  logic [W-1:0] pair_word [NCH];
  logic [NCH-1:0] zflag;

  assign fmt = fmt_e'(mode_pin_i | mode_reg_i);  // R1

  asr_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .async_i({sdata_i, lrclk_i, bclk_i}),
    .sync_o(pins_s)
  );
  assign {sd_s, lr_s, bclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= bclk_s;
  end

  // Falling edge for DSP format, rising edge otherwise (R2, R5).
  assign smp_en = (fmt == FMT_DSP) ? (!bclk_s && bclk_q) : (bclk_s && !bclk_q);

  asr_field_capture #(.W(W), .MAX_SLOTS(MAX_SLOTS), .RJ_SLOTS(RJ_SLOTS)) cap_i (
    .clk(clk), .rst(rst),
    .smp_en_i(smp_en), .lr_i(lr_s), .sd_i(sd_s),
    .fmt_i(fmt), .rj_len_i(rj_len_i),
    .commit_o(commit), .commit_left_o(commit_left), .word_o(word)
  );

  // Pair assembly: left is staged, right completes the pair (R7).
  assign pair_fire    = commit && !commit_left && have_left_q;
  assign pair_word[0] = staged_q;
  assign pair_word[1] = word;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q     <= '0;
      have_left_q  <= 1'b0;
      left_o       <= '0;
      right_o      <= '0;
      pair_valid_o <= 1'b0;
    end else begin
      pair_valid_o <= pair_fire;
      if (commit && commit_left) begin
        staged_q    <= word;
        have_left_q <= 1'b1;
      end else if (pair_fire) begin
        left_o      <= staged_q;
        right_o     <= word;
        have_left_q <= 1'b0;
      end
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_zero
      asr_zero_watch #(.W(W), .LIMIT(ZERO_FRAMES)) zw_i (
        .clk(clk), .rst(rst),
        .strobe_i(pair_fire), .word_i(pair_word[c]),
        .flag_o(zflag[c])
      );
    end
  endgenerate

  assign zero_left_o  = zflag[0];
  assign zero_right_o = zflag[1];

endmodule

// File: rtl/asr_checker.sv
module asr_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         pair_valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         zero_left_o,
  input logic         zero_right_o
);

  p_pair_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |=> !pair_valid_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

  p_zl_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_left_o) |-> pair_valid_o);

  p_zr_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_right_o) |-> pair_valid_o);

  p_zl_word_r8: assert property (@(posedge clk) disable iff (rst)
    zero_left_o |-> (left_o == '0));

  p_zr_word_r8: assert property (@(posedge clk) disable iff (rst)
    zero_right_o |-> (right_o == '0));

endmodule

bind audio_serial_rx asr_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .pair_valid_o(pair_valid_o),
  .left_o(left_o), .right_o(right_o),
  .zero_left_o(zero_left_o), .zero_right_o(zero_right_o)
);

// File: tb/audio_serial_rx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_rx_tb_top;

  localparam int W    = 24;
  localparam int ZLIM = 4;
  localparam time HB  = 80ns;

  logic clk = 1'b0, rst = 1'b1;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0] mode_pin = 2'b00, mode_reg = 2'b00, rj_code = 2'b00;
  logic [W-1:0] left_o, right_o;
  logic pair_valid_o, zero_left_o, zero_right_o;

  int checks = 0, fails = 0;
  logic dsp_drive = 1'b0;
  logic done = 1'b0;
  logic [W-1:0] exp_l [$];
  logic [W-1:0] exp_r [$];
  string        exp_t [$];
  logic [W-1:0] last_l, last_r;

  always #10 clk = ~clk;

  audio_serial_rx #(.W(W), .ZERO_FRAMES(ZLIM)) dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .mode_pin_i(mode_pin), .mode_reg_i(mode_reg), .rj_len_i(rj_code),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o),
    .zero_left_o(zero_left_o), .zero_right_o(zero_right_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Monitor: scoreboard pop on every delivered pair (R7).
  logic pv_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && pair_valid_o) begin
      check("R7 strobe one cycle", {23'd0, pv_prev}, 24'd0);
      if (exp_l.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected pair actual=%h/%h expected=none", left_o, right_o);
      end else begin
        check({exp_t[0], " left"}, left_o, exp_l[0]);
        check({exp_t[0], " right"}, right_o, exp_r[0]);
        void'(exp_l.pop_front()); void'(exp_r.pop_front()); void'(exp_t.pop_front());
      end
    end
    pv_prev = rst ? 1'b0 : pair_valid_o;
  end

  function automatic logic [W-1:0] top_bits(input logic [W-1:0] v, input int n);
    if (n >= W) return v;
    return v & ~((24'h1 << (W - n)) - 24'h1);
  endfunction

  function automatic logic bit_of(input logic [W-1:0] v, input int j);
    if (j < W) return v[W-1-j];
    return 1'b1;  // overflow bits beyond the 24th
  endfunction

  task automatic put_bit(input logic lr, input logic d);
    if (dsp_drive) begin
      bclk = 1'b1; lrclk = lr; sdata = d; #HB; bclk = 1'b0; #HB;
    end else begin
      bclk = 1'b0; lrclk = lr; sdata = d; #HB; bclk = 1'b1; #HB;
    end
  endtask

  task automatic send_half(input logic [1:0] f, input logic is_left,
                           input logic [W-1:0] v, input int n, input int rl);
    for (int i = 0; i < 32; i++) begin
      logic lr, d;
      case (f)
        2'b10: begin lr = is_left;  d = (i < n) ? bit_of(v, i) : 1'b0; end
        2'b01: begin lr = !is_left; d = (i >= 1 && i - 1 < n) ? bit_of(v, i - 1) : 1'b0; end
        2'b00: begin lr = is_left;  d = (i >= 32 - rl) ? v[W-1-(i-(32-rl))] : 1'b1; end
        default: begin lr = (i == 0); d = (i >= 1 && i - 1 < n) ? bit_of(v, i - 1) : 1'b0; end
      endcase
      put_bit(lr, d);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [W-1:0] l, input logic [W-1:0] r,
                            input int n, input int rl, input string tag);
    logic [W-1:0] el, er;
    el = (f == 2'b00) ? top_bits(l, rl) : top_bits(l, n);
    er = (f == 2'b00) ? top_bits(r, rl) : top_bits(r, n);
    exp_l.push_back(el); exp_r.push_back(er); exp_t.push_back(tag);
    last_l = el; last_r = er;
    send_half(f, 1'b1, l, n, rl);
    send_half(f, 1'b0, r, n, rl);
  endtask

  task automatic do_reset(input logic [1:0] pin, input logic [1:0] reg_c, input logic [1:0] rjc);
    rst = 1'b1; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    mode_pin = pin; mode_reg = reg_c; rj_code = rjc;
    dsp_drive = ((pin | reg_c) == 2'b11);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // Preamble at the right-field level so the first left field opens a boundary.
    for (int i = 0; i < 2; i++) put_bit(((pin | reg_c) == 2'b01), 1'b1);
  endtask

  task automatic flush_and_drain(input logic [1:0] f, input string req);
    if (f == 2'b11) begin
      put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0);
    end else begin
      for (int i = 0; i < 2; i++) put_bit(f != 2'b01, 1'b0);
    end
    repeat (30) @(posedge clk);
    checks++;
    if (exp_l.size() != 0) begin
      fails++;
      $display("FAIL %s pairs missing actual=%0d expected=0", req, exp_l.size());
      exp_l.delete(); exp_r.delete(); exp_t.delete();
    end
  endtask

  task automatic zero_group(input int nz, input logic tail, input logic exp_zl, input logic exp_zr);
    do_reset(2'b10, 2'b00, 2'b00);
    for (int k = 0; k < nz; k++) send_frame(2'b10, 24'h0, 24'h0, 24, 24, "R8 zero pair");
    if (tail) send_frame(2'b10, 24'h000100, 24'h0, 24, 24, "R8 resume pair");
    flush_and_drain(2'b10, "R8");
    @(negedge clk);
    check("R8 zero_left", {23'd0, zero_left_o}, {23'd0, exp_zl});
    check("R8 zero_right", {23'd0, zero_right_o}, {23'd0, exp_zr});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 left after reset", left_o, 24'h0);
    check("R9 right after reset", right_o, 24'h0);
    check("R9 flags/strobe after reset", {21'd0, pair_valid_o, zero_left_o, zero_right_o}, 24'h0);

    // R3 left-justified, full words; R1 via pin code 10
    do_reset(2'b10, 2'b00, 2'b00);
    send_frame(2'b10, 24'hA5C3F1, 24'h123456, 24, 24, "R3 LJ 24b");
    send_frame(2'b10, 24'h800001, 24'h7FFFFE, 24, 24, "R3 LJ 24b");
    flush_and_drain(2'b10, "R3");
    // R10: outputs hold after the last strobe
    repeat (50) @(posedge clk);
    @(negedge clk);
    check("R10 left held", left_o, last_l);
    check("R10 right held", right_o, last_r);

    // R6 short and long words in left-justified format
    do_reset(2'b10, 2'b00, 2'b00);
    send_frame(2'b10, 24'hFFFFFF, 24'hABCDEF, 16, 24, "R6 LJ 16b low zeros");
    send_frame(2'b10, 24'h13579B, 24'hFEDCBA, 28, 24, "R6 LJ 28b overflow dropped");
    flush_and_drain(2'b10, "R6");

    // R2 I2S via register code
    do_reset(2'b00, 2'b01, 2'b00);
    send_frame(2'b01, 24'h5A5A5A, 24'hC0FFEE, 24, 24, "R2 I2S 24b");
    send_frame(2'b01, 24'hFFFFFF, 24'h3C3C3C, 18, 24, "R2 I2S 18b");
    flush_and_drain(2'b01, "R2");

    // R4 right-justified, each length code
    do_reset(2'b00, 2'b00, 2'b00);
    send_frame(2'b00, 24'h9ABCDE, 24'h010203, 24, 24, "R4 RJ 24b");
    flush_and_drain(2'b00, "R4");
    do_reset(2'b00, 2'b00, 2'b01);
    send_frame(2'b00, 24'hFEDCBA, 24'h5A5A5A, 20, 20, "R4 RJ 20b");
    flush_and_drain(2'b00, "R4");
    do_reset(2'b00, 2'b00, 2'b10);
    send_frame(2'b00, 24'h8001FF, 24'h7FFE00, 16, 16, "R4 RJ 16b");
    flush_and_drain(2'b00, "R4");

    // R1 + R5: DSP reached only by OR of pin 10 and register 01
    do_reset(2'b10, 2'b01, 2'b00);
    send_frame(2'b11, 24'hDEADBE, 24'h2468AC, 24, 24, "R5 DSP 24b (R1 OR)");
    send_frame(2'b11, 24'hFFFFFF, 24'h0F0F0F, 20, 24, "R5 DSP 20b");
    flush_and_drain(2'b11, "R5");

    // R9: reset clears a populated output
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 left cleared by reset", left_o, 24'h0);
    check("R9 right cleared by reset", right_o, 24'h0);

    // R8 zero flags: at threshold, past it, and one channel resuming
    zero_group(ZLIM, 1'b0, 1'b0, 1'b0);
    zero_group(ZLIM + 1, 1'b0, 1'b1, 1'b1);
    zero_group(ZLIM + 1, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule